// File: doc/BRIEF.md
# Interrupt Controller Command Sequencer

This block sits on the processor side of an eight-level interrupt controller and turns processor writes into held configuration. A write is one clock cycle with chip-select and write strobe both high; a single address bit and an 8-bit data byte say what the write means. After reset the block is uninitialized. A command write with data bit 4 set starts an ordered setup sequence. That sequence has two mandatory words and up to two optional ones, and each optional word is expected only when the first word asks for it. After the last expected word, the block is initialized and takes run-time words in any order: a mask load, an end-of-service command, and a status read selection.

Every result is a registered output that the priority, acknowledge and cascade blocks read directly. These outputs are the device role, the vector spacing, the vector address bits, the cascade and mode words, the mask, and the status read selection. There are also two one-cycle command pulses: one clears the in-service state and one reports an end-of-service command.

Top module: `intc_cmd_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, every output is 0.
- R2: A write with a0=0 and din[4]=1 is accepted in any state and restarts setup. On the next cycle the outputs are as follows. init_done, irq_mask, status_isr and mode_word are 0. cascaded is the inverse of din[1]. vec_step4 equals din[2]. vec_mid equals din[7:5]. isr_clear is high for exactly that one cycle.
- R3: The first write with a0=1 after a restart loads vec_high with din.
- R4: When cascaded is 1, the next write with a0=1 loads casc_word. When cascaded is 0, no such word is expected.
- R5: When the restart word had din[0]=1, the last write with a0=1 in the sequence loads mode_word. This write comes after the cascade word if one is expected.
- R6: init_done rises on the cycle after the last expected setup word. That last word is the second, third or fourth, depending on R4 and R5.
- R7: Before init_done, a write with a0=0 and din[4]=0 has no effect: no eoi_valid pulse and no change to status_isr.
- R8: When init_done=1, a write with a0=1 loads irq_mask with din on the next cycle.
- R9: When init_done=1, a write with a0=0, din[4]=0 and din[3]=0 raises eoi_valid for one cycle. In that cycle eoi_cmd equals din[7:5] and eoi_level equals din[2:0].
- R10: When init_done=1, a write with a0=0, din[4]=0, din[3]=1 and din[1]=1 sets status_isr to din[0]. The same write with din[1]=0 leaves status_isr unchanged.
- R11: A cycle in which cs or wr is low changes no output, and both pulses are low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select |
| wr | input | 1 | Write strobe, one cycle per write |
| a0 | input | 1 | Address bit: 0 command, 1 data word |
| din | input | 8 | Write data |
| init_done | output | 1 | Setup sequence complete |
| cascaded | output | 1 | 1 when cascaded operation was selected |
| vec_step4 | output | 1 | 1 for 4-byte vector spacing, 0 for 8-byte |
| vec_mid | output | 3 | Vector address bits A7-A5 |
| vec_high | output | 8 | Vector address bits A15-A8 |
| casc_word | output | 8 | Cascade configuration word |
| mode_word | output | 8 | Optional mode word, 0 when not supplied |
| irq_mask | output | 8 | Interrupt mask |
| status_isr | output | 1 | Status read select: 1 in-service, 0 request |
| isr_clear | output | 1 | One-cycle pulse to clear in-service state |
| eoi_valid | output | 1 | One-cycle end-of-service command pulse |
| eoi_cmd | output | 3 | Command code of that pulse |
| eoi_level | output | 3 | Level field of that pulse |

## Verification
Every result of a write shows up exactly one clock edge after the cycle in which the write is presented. This holds for the held fields, the initialization flag and the two pulses, and the pulses drop again one edge later. The bench drives each write on a falling edge, holds it for one cycle, and compares all outputs on every falling edge with a behavioural model that updates on the same rising edge the design uses. Its directed checks therefore read a result in the half cycle right after that edge.

// File: rtl/intc_seq_pkg.sv
package intc_seq_pkg;
  localparam int BIT_WANT4  = 0;
  localparam int BIT_SINGLE = 1;
  localparam int BIT_STEP4  = 2;
  localparam int BIT_OPSEL  = 3;
  localparam int BIT_START  = 4;
  localparam int BIT_RDSEL  = 0;
  localparam int BIT_RDEN   = 1;
  localparam int FLD_HI_LSB = 5;

  typedef enum logic [2:0] {
    ST_UNINIT, ST_WANT2, ST_WANT3, ST_WANT4, ST_RUN
  } seq_st_e;

  typedef enum logic [2:0] {
    WK_NONE, WK_START, WK_OPEOI, WK_OPRD, WK_DATA
  } wkind_e;
endpackage

// File: rtl/intc_wr_decode.sv
module intc_wr_decode
  import intc_seq_pkg::*;
(
  input  logic   cs,
  input  logic   wr,
  input  logic   a0,
  input  logic   start_bit,
  input  logic   opsel_bit,
  output wkind_e kind
);
  always_comb begin
    kind = WK_NONE;
    if (cs && wr) begin
      if (a0)             kind = WK_DATA;
      else if (start_bit) kind = WK_START;
      else if (opsel_bit) kind = WK_OPRD;
      else                kind = WK_OPEOI;
    end
  end
endmodule

// File: rtl/intc_init_seq.sv
module intc_init_seq
  import intc_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  wkind_e kind,
  input  logic   want3_in,
  input  logic   want4_in,
  output logic   ld_w2,
  output logic   ld_w3,
  output logic   ld_w4,
  output logic   ld_run,
  output logic   running
);
  seq_st_e st_q, st_d;
  logic    want3_q, want3_d;
  logic    want4_q, want4_d;
  logic    is_data;

  assign is_data = (kind == WK_DATA);

  always_comb begin
    st_d    = st_q;
    want3_d = want3_q;
    want4_d = want4_q;
    if (kind == WK_START) begin
      st_d    = ST_WANT2;
      want3_d = want3_in;
      want4_d = want4_in;
    end else if (is_data) begin
      unique case (st_q)
        ST_WANT2: st_d = want3_q ? ST_WANT3 : (want4_q ? ST_WANT4 : ST_RUN);
        ST_WANT3: st_d = want4_q ? ST_WANT4 : ST_RUN;
        ST_WANT4: st_d = ST_RUN;
        default:  st_d = st_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_UNINIT;
      want3_q <= 1'b0;
      want4_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      want3_q <= want3_d;
      want4_q <= want4_d;
    end
  end

  assign ld_w2   = is_data && (st_q == ST_WANT2);
  assign ld_w3   = is_data && (st_q == ST_WANT3);
  assign ld_w4   = is_data && (st_q == ST_WANT4);
  assign ld_run  = is_data && (st_q == ST_RUN);
  assign running = (st_q == ST_RUN);
endmodule

// File: rtl/intc_cfg_regs.sv
module intc_cfg_regs
  import intc_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  wkind_e        kind,
  input  logic [DW-1:0] din,
  input  logic          ld_w2,
  input  logic          ld_w3,
  input  logic          ld_w4,
  input  logic          ld_run,
  input  logic          running,
  output logic          cascaded,
  output logic          vec_step4,
  output logic [LW-1:0] vec_mid,
  output logic [DW-1:0] vec_high,
  output logic [DW-1:0] casc_word,
  output logic [DW-1:0] mode_word,
  output logic [DW-1:0] irq_mask,
  output logic          status_isr,
  output logic          isr_clear,
  output logic          eoi_valid,
  output logic [LW-1:0] eoi_cmd,
  output logic [LW-1:0] eoi_level
);
  logic          is_start, en_eoi, en_rd;
  logic          casc_d, step_d, stat_d, clr_d, eoi_d;
  logic [LW-1:0] mid_d, cmd_d, lvl_d;
  logic [DW-1:0] high_d, cw_d, mw_d, mask_d;

  assign is_start = (kind == WK_START);
  assign en_eoi   = running && (kind == WK_OPEOI);
  assign en_rd    = running && (kind == WK_OPRD) && din[BIT_RDEN];

  always_comb begin
    casc_d = cascaded;
    step_d = vec_step4;
    mid_d  = vec_mid;
    high_d = vec_high;
    cw_d   = casc_word;
    mw_d   = mode_word;
    mask_d = irq_mask;
    stat_d = status_isr;
    clr_d  = 1'b0;
    eoi_d  = 1'b0;
    cmd_d  = eoi_cmd;
    lvl_d  = eoi_level;
    if (is_start) begin
      casc_d = ~din[BIT_SINGLE];
      step_d = din[BIT_STEP4];
      mid_d  = din[FLD_HI_LSB +: LW];
      mw_d   = '0;
      mask_d = '0;
      stat_d = 1'b0;
      clr_d  = 1'b1;
    end
    if (ld_w2)  high_d = din;
    if (ld_w3)  cw_d   = din;
    if (ld_w4)  mw_d   = din;
    if (ld_run) mask_d = din;
    if (en_rd)  stat_d = din[BIT_RDSEL];
    if (en_eoi) begin
      eoi_d = 1'b1;
      cmd_d = din[FLD_HI_LSB +: LW];
      lvl_d = din[LW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cascaded   <= 1'b0;
      vec_step4  <= 1'b0;
      vec_mid    <= '0;
      vec_high   <= '0;
      casc_word  <= '0;
      mode_word  <= '0;
      irq_mask   <= '0;
      status_isr <= 1'b0;
      isr_clear  <= 1'b0;
      eoi_valid  <= 1'b0;
      eoi_cmd    <= '0;
      eoi_level  <= '0;
    end else begin
      cascaded   <= casc_d;
      vec_step4  <= step_d;
      vec_mid    <= mid_d;
      vec_high   <= high_d;
      casc_word  <= cw_d;
      mode_word  <= mw_d;
      irq_mask   <= mask_d;
      status_isr <= stat_d;
      isr_clear  <= clr_d;
      eoi_valid  <= eoi_d;
      eoi_cmd    <= cmd_d;
      eoi_level  <= lvl_d;
    end
  end
endmodule

// File: rtl/intc_cmd_seq.sv
module intc_cmd_seq
  import intc_seq_pkg::*;
#(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          wr,
  input  logic          a0,
  input  logic [DW-1:0] din,
  output logic          init_done,
  output logic          cascaded,
  output logic          vec_step4,
  output logic [LW-1:0] vec_mid,
  output logic [DW-1:0] vec_high,
  output logic [DW-1:0] casc_word,
  output logic [DW-1:0] mode_word,
  output logic [DW-1:0] irq_mask,
  output logic          status_isr,
  output logic          isr_clear,
  output logic          eoi_valid,
  output logic [LW-1:0] eoi_cmd,
  output logic [LW-1:0] eoi_level
);
  wkind_e kind;
  logic   ld_w2, ld_w3, ld_w4, ld_run, running;

  intc_wr_decode u_dec (
    .cs        (cs),
    .wr        (wr),
    .a0        (a0),
    .start_bit (din[BIT_START]),
    .opsel_bit (din[BIT_OPSEL]),
    .kind      (kind)
  );

  intc_init_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .kind     (kind),
    .want3_in (~din[BIT_SINGLE]),
    .want4_in (din[BIT_WANT4]),
    .ld_w2    (ld_w2),
    .ld_w3    (ld_w3),
    .ld_w4    (ld_w4),
    .ld_run   (ld_run),
    .running  (running)
  );

  intc_cfg_regs #(.DW(DW), .LW(LW)) u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .kind       (kind),
    .din        (din),
    .ld_w2      (ld_w2),
    .ld_w3      (ld_w3),
    .ld_w4      (ld_w4),
    .ld_run     (ld_run),
    .running    (running),
    .cascaded   (cascaded),
    .vec_step4  (vec_step4),
    .vec_mid    (vec_mid),
    .vec_high   (vec_high),
    .casc_word  (casc_word),
    .mode_word  (mode_word),
    .irq_mask   (irq_mask),
    .status_isr (status_isr),
    .isr_clear  (isr_clear),
    .eoi_valid  (eoi_valid),
    .eoi_cmd    (eoi_cmd),
    .eoi_level  (eoi_level)
  );

  assign init_done = running;
endmodule

// File: rtl/intc_cmd_seq_chk.sv
module intc_cmd_seq_chk #(
  parameter int DW = 8,
  parameter int LW = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          wr,
  input logic          a0,
  input logic [DW-1:0] din,
  input logic          init_done,
  input logic [DW-1:0] irq_mask,
  input logic          status_isr,
  input logic          isr_clear,
  input logic          eoi_valid,
  input logic [LW-1:0] eoi_cmd
);
  logic wr_go;
  assign wr_go = cs && wr;

  p_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !a0 && din[4]) |=> (!init_done && isr_clear && irq_mask == '0 && !status_isr));

  p_early_op_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !a0 && !din[4] && !init_done) |=> (!eoi_valid && $stable(status_isr)));

  p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && a0 && init_done) |=> (irq_mask == $past(din)));

  p_eoi_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !a0 && !din[4] && !din[3] && init_done) |=> (eoi_valid && eoi_cmd == $past(din[7:5])));

  p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && !a0 && !din[4] && din[3] && !din[1]) |=> $stable(status_isr));

  p_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> ($stable(irq_mask) && $stable(init_done) && !eoi_valid && !isr_clear));
endmodule

bind intc_cmd_seq intc_cmd_seq_chk #(.DW(DW), .LW(LW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cs         (cs),
  .wr         (wr),
  .a0         (a0),
  .din        (din),
  .init_done  (init_done),
  .irq_mask   (irq_mask),
  .status_isr (status_isr),
  .isr_clear  (isr_clear),
  .eoi_valid  (eoi_valid),
  .eoi_cmd    (eoi_cmd)
);

// File: tb/intc_cmd_seq_bench.sv
`timescale 1ns/1ps
module intc_cmd_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, wr = 1'b0, a0 = 1'b0;
  logic [7:0] din = 8'h00;
  logic       init_done, cascaded, vec_step4, status_isr, isr_clear, eoi_valid;
  logic [2:0] vec_mid, eoi_cmd, eoi_level;
  logic [7:0] vec_high, casc_word, mode_word, irq_mask;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_cmd_seq u_intc_cmd_seq (
    .clk(clk), .rst_n(rst_n), .cs(cs), .wr(wr), .a0(a0), .din(din),
    .init_done(init_done), .cascaded(cascaded), .vec_step4(vec_step4),
    .vec_mid(vec_mid), .vec_high(vec_high), .casc_word(casc_word),
    .mode_word(mode_word), .irq_mask(irq_mask), .status_isr(status_isr),
    .isr_clear(isr_clear), .eoi_valid(eoi_valid), .eoi_cmd(eoi_cmd),
    .eoi_level(eoi_level)
  );

  // behavioural reference: phase 0 idle, 1..3 waiting for words 2..4, 4 running
  int phase;
  bit m_w3, m_w4, m_done, m_casc, m_step, m_stat, m_clr, m_eoi;
  int m_mid, m_high, m_cw, m_mw, m_mask, m_cmd, m_lvl;

  function automatic int after_w2();
    return m_w3 ? 2 : (m_w4 ? 3 : 4);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase = 0; m_w3 = 0; m_w4 = 0; m_casc = 0; m_step = 0; m_stat = 0;
      m_clr = 0; m_eoi = 0; m_mid = 0; m_high = 0; m_cw = 0; m_mw = 0;
      m_mask = 0; m_cmd = 0; m_lvl = 0;
    end else begin
      m_clr = 0; m_eoi = 0;
      if (cs && wr) begin
        if (!a0 && din[4]) begin
          phase = 1; m_w3 = !din[1]; m_w4 = din[0]; m_casc = !din[1];
          m_step = din[2]; m_mid = din[7:5]; m_mw = 0; m_mask = 0;
          m_stat = 0; m_clr = 1;
        end else if (a0) begin
          case (phase)
            1: begin m_high = din; phase = after_w2(); end
            2: begin m_cw = din; phase = m_w4 ? 3 : 4; end
            3: begin m_mw = din; phase = 4; end
            4: m_mask = din;
            default: ;
          endcase
        end else if (phase == 4) begin
          if (!din[3]) begin m_eoi = 1; m_cmd = din[7:5]; m_lvl = din[2:0]; end
          else if (din[1]) m_stat = din[0];
        end
      end
    end
    m_done = (phase == 4);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // compare every output against the model once per cycle
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 init_done", init_done, m_done);
      chk("R2 cascaded", cascaded, m_casc);
      chk("R2 vec_step4", vec_step4, m_step);
      chk("R2 vec_mid", vec_mid, m_mid);
      chk("R2 isr_clear", isr_clear, m_clr);
      chk("R3 vec_high", vec_high, m_high);
      chk("R4 casc_word", casc_word, m_cw);
      chk("R5 mode_word", mode_word, m_mw);
      chk("R8 irq_mask", irq_mask, m_mask);
      chk("R10 status_isr", status_isr, m_stat);
      chk("R9 eoi_valid", eoi_valid, m_eoi);
      if (m_eoi) begin
        chk("R9 eoi_cmd", eoi_cmd, m_cmd);
        chk("R9 eoi_level", eoi_level, m_lvl);
      end
    end
  end

  task automatic put(input bit a, input logic [7:0] d, input bit c = 1, input bit w = 1);
    @(negedge clk);
    cs = c; wr = w; a0 = a; din = d;
    @(negedge clk);
    cs = 0; wr = 0; a0 = 0; din = 8'h00;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset init_done", init_done, 0);
    chk("R1 reset mask", irq_mask, 0);
    chk("R1 reset vec_high", vec_high, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release pulses", {isr_clear, eoi_valid, status_isr}, 0);

    // single device, no fourth word: two words complete setup
    put(0, 8'hB6);
    chk("R2 restart pulse", isr_clear, 1);
    chk("R2 vec_mid", vec_mid, 3'b101);
    chk("R2 single", cascaded, 0);
    chk("R2 step4", vec_step4, 1);
    put(1, 8'h40);
    chk("R6 done after two", init_done, 1);
    chk("R3 high", vec_high, 8'h40);
    put(1, 8'h5A);
    chk("R8 mask", irq_mask, 8'h5A);
    put(0, 8'h63);
    chk("R9 pulse", eoi_valid, 1);
    chk("R9 cmd", eoi_cmd, 3'b011);
    chk("R9 level", eoi_level, 3'b011);
    @(negedge clk);
    chk("R9 pulse width", eoi_valid, 0);
    put(0, 8'h0B);
    chk("R10 select isr", status_isr, 1);
    put(0, 8'h08);
    chk("R10 no rd enable", status_isr, 1);
    put(1, 8'hFF, 0, 1);
    chk("R11 cs low", irq_mask, 8'h5A);
    put(1, 8'hFF, 1, 0);
    chk("R11 wr low", irq_mask, 8'h5A);

    // cascaded with fourth word, op words during setup ignored
    put(0, 8'h11);
    chk("R2 mask cleared", irq_mask, 0);
    chk("R2 status cleared", status_isr, 0);
    chk("R2 cascaded", cascaded, 1);
    put(0, 8'h20);
    chk("R7 no eoi in setup", eoi_valid, 0);
    put(1, 8'h12);
    chk("R6 not yet", init_done, 0);
    put(0, 8'h0B);
    chk("R7 no select in setup", status_isr, 0);
    put(1, 8'h0F);
    chk("R4 casc", casc_word, 8'h0F);
    chk("R6 wait fourth", init_done, 0);
    put(1, 8'h03);
    chk("R5 mode", mode_word, 8'h03);
    chk("R6 done after four", init_done, 1);

    // cascaded, no fourth word
    put(0, 8'h30);
    chk("R2 mode cleared", mode_word, 0);
    put(1, 8'h80); put(1, 8'hA5);
    chk("R4 casc three", casc_word, 8'hA5);
    chk("R6 done after three", init_done, 1);

    // single with fourth word: third slot skipped
    put(0, 8'h13);
    put(1, 8'h21);
    put(1, 8'h1D);
    chk("R5 mode skip third", mode_word, 8'h1D);
    chk("R4 casc unchanged", casc_word, 8'hA5);
    chk("R6 done", init_done, 1);

    // restart mid-sequence
    put(0, 8'h11); put(1, 8'h44); put(0, 8'h16);
    chk("R2 restart mid", init_done, 0);
    put(1, 8'h77);
    chk("R3 reloaded", vec_high, 8'h77);
    chk("R6 done", init_done, 1);

    // random traffic, model comparison every cycle
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      cs = ($urandom % 4) != 0; wr = ($urandom % 3) != 0;
      a0 = $urandom % 2;
      din = $urandom;
      if (($urandom % 8) != 0 && !a0) din[4] = 1'b0;
    end
    @(negedge clk);
    cs = 0; wr = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++; checks++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule